// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a countdown watchdog that sits on a simple 32-bit register bus (address, write enable, write data, combinational read data). Software programs a reload value, enables counting, and must keep restarting the count before it runs out. The count moves down by one on every clock cycle in which the tick enable input is high. When the count runs out the first time, the block raises an interrupt and starts a new countdown from the reload value. If the interrupt has not been cleared by the time the second countdown runs out, and reset generation is enabled, the block drives a system reset request that stays high until the block itself is reset.

A 32-bit key register protects the configuration. Writing the key value opens the other registers to writes, and writing any other value closes them again. A typical refresh from software is therefore: open, write a new reload value, close. Stopping the watchdog means opening it and writing zero to the control register.

The bus has no back-pressure: every write completes in the cycle its write enable is sampled, and read data follows the address in the same cycle. The tick input is a plain level enable, not a handshake.

Top module: `guard_timer`

## Requirements
- R1: After reset the reload value and the count both equal the parameter LOAD_RST (all ones by default), the control register reads 0, the registers are open for writing (key register reads 0), and irq_o and sys_rst_o are low.
- R2: Register offsets: 0x000 reload value (read/write), 0x004 current count (read only), 0x008 control (bit 0 run, bit 1 reset enable), 0x00C interrupt clear (write only, reads 0), 0xC00 key. Any other offset reads 0.
- R3: A write of 0x1ACCE551 to offset 0xC00 opens the registers; a write of any other value closes them. Bit 0 of a read at 0xC00 is 1 while closed and 0 while open.
- R4: While closed, writes to offsets 0x000, 0x008 and 0x00C have no effect on the reload value, the control register, the count or the interrupt.
- R5: An accepted write to offset 0x000 stores the new reload value and restarts the count from it in the next cycle.
- R6: With control bit 0 set, each cycle with tick_en high lowers the count by one; a tick while the count is 0 is an expiry and puts the reload value back into the count, so one countdown lasts reload+1 ticks. Setting bit 0 when it was clear also restarts the count from the reload value.
- R7: An expiry sets the pending interrupt; irq_o is high while the interrupt is pending and control bit 0 is set.
- R8: An accepted write of any value to offset 0x00C clears the pending interrupt and restarts the count from the reload value.
- R9: An expiry that happens while the interrupt is still pending and control bit 1 is set drives sys_rst_o high, and it stays high until rst_n is asserted, whatever is written afterwards.
- R10: sys_rst_o never rises while control bit 1 is clear.
- R11: With control bit 0 clear the count holds, irq_o is low and no expiry occurs.
- R12: When an accepted write that restarts the count (offset 0x000, 0x00C, or setting bit 0) coincides with a tick, the restart wins: the count takes the reload value and no expiry happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, write taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt, first expiry |
| sys_rst_o | output | 1 | Sticky system reset request, second expiry |

## Verification
The bench sweeps small reload values from 0 upward and checks the count after every tick, so an off-by-one in the period (expiring at 1 instead of 0, or reloading one tick late) shows as a wrong count or an interrupt one tick early or late. It checks that reset needs two full countdowns with the interrupt left pending, that clearing between them prevents it, and that reset stays high after the control is zeroed; a design that escalated on the first expiry or dropped the request would fail there. The key register is probed with the correct key, a one-bit-off key and zero, and closed writes to every guarded register are followed by reads and output checks. A tick that coincides with a clear is checked to leave the count at the reload value with no interrupt, which catches a design that let the decrement or expiry win.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 12;

  localparam logic [BUS_AW-1:0] OFF_RELOAD = 12'h000;
  localparam logic [BUS_AW-1:0] OFF_COUNT  = 12'h004;
  localparam logic [BUS_AW-1:0] OFF_CTRL   = 12'h008;
  localparam logic [BUS_AW-1:0] OFF_ICLR   = 12'h00C;
  localparam logic [BUS_AW-1:0] OFF_KEY    = 12'hC00;

  localparam logic [BUS_DW-1:0] OPEN_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/guard_regs.sv
module guard_regs
  import guard_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic [CNT_W-1:0]  load_q,
  output ctrl_t             ctrl_q,
  output logic              closed_q,
  output logic              reload,
  output logic [CNT_W-1:0]  reload_val,
  output logic              iclr
);
  logic wr_ok, wr_load, wr_ctrl, wr_key, run_rise;

  assign wr_key   = bus_we && (bus_addr == OFF_KEY);
  assign wr_ok    = bus_we && !closed_q;
  assign wr_load  = wr_ok && (bus_addr == OFF_RELOAD);
  assign wr_ctrl  = wr_ok && (bus_addr == OFF_CTRL);
  assign iclr     = wr_ok && (bus_addr == OFF_ICLR);
  assign run_rise = wr_ctrl && bus_wdata[0] && !ctrl_q.run;

  assign reload     = wr_load || iclr || run_rise;
  assign reload_val = wr_load ? bus_wdata[CNT_W-1:0] : load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= LOAD_RST;
      ctrl_q   <= '0;
      closed_q <= 1'b0;
    end else begin
      if (wr_load) load_q <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[1:0]);
      if (wr_key)  closed_q <= (bus_wdata != OPEN_KEY);
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_RELOAD: bus_rdata = BUS_DW'(load_q);
      OFF_COUNT:  bus_rdata = BUS_DW'(count);
      OFF_CTRL:   bus_rdata = BUS_DW'(ctrl_q);
      OFF_KEY:    bus_rdata = BUS_DW'(closed_q);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/guard_counter.sv
module guard_counter #(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic step;

  assign step   = run && tick && !reload;
  assign expire = step && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= LOAD_RST;
    else if (reload) count <= reload_val;
    else if (expire) count <= load_q;
    else if (step)   count <= count - 1'b1;
  end
endmodule

// File: rtl/guard_escalate.sv
module guard_escalate
  import guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  expire,
  input  logic  iclr,
  input  ctrl_t ctrl_q,
  output logic  irq_o,
  output logic  sys_rst_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      sys_rst_o <= 1'b0;
    end else begin
      if (iclr)        pend_q <= 1'b0;
      else if (expire) pend_q <= 1'b1;
      if (expire && pend_q && ctrl_q.rst_en) sys_rst_o <= 1'b1;
    end
  end

  assign irq_o = pend_q && ctrl_q.run;
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic [CNT_W-1:0] load_q, count, reload_val;
  ctrl_t            ctrl_q;
  logic             closed_q, reload, iclr, expire;

  guard_regs #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .count(count), .bus_rdata(bus_rdata),
    .load_q(load_q), .ctrl_q(ctrl_q), .closed_q(closed_q),
    .reload(reload), .reload_val(reload_val), .iclr(iclr)
  );

  guard_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .tick(tick_en),
    .reload(reload), .reload_val(reload_val), .load_q(load_q),
    .count(count), .expire(expire)
  );

  guard_escalate u_esc (
    .clk(clk), .rst_n(rst_n), .expire(expire), .iclr(iclr),
    .ctrl_q(ctrl_q), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
  import guard_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic              irq_o,
  input logic              sys_rst_o,
  input logic              closed_q,
  input logic [CNT_W-1:0]  load_q,
  input ctrl_t             ctrl_q,
  input logic [CNT_W-1:0]  count,
  input logic              expire
);
  p_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_KEY && bus_wdata == OPEN_KEY) |=> !closed_q);

  p_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_KEY && bus_wdata != OPEN_KEY) |=> closed_q);

  p_closed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (closed_q && bus_we && bus_addr != OFF_KEY) |=> ($stable(load_q) && $stable(ctrl_q)));

  p_expire_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == $past(load_q)));

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !bus_we) |=> irq_o);

  p_iclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!closed_q && bus_we && bus_addr == OFF_ICLR) |=> !irq_o);

  p_rst_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> sys_rst_o);

  p_rst_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(ctrl_q.rst_en));

  p_stop_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> !irq_o);

  p_stop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !bus_we) |=> $stable(count));
endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o),
  .closed_q(closed_q), .load_q(load_q), .ctrl_q(ctrl_q),
  .count(count), .expire(expire)
);

// File: tb/tb_guard_timer.sv
module tb_guard_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, sys_rst_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                          A_ICLR = 12'h00C, A_KEY = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  always #4 clk = ~clk;

  guard_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    rd(A_LOAD, v); check("R1 reload", v, 32'hFFFF_FFFF);
    rd(A_CNT, v);  check("R1 count", v, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_KEY, v);  check("R1 key open", v, 0);
    check("R1 irq", irq_o, 0);
    check("R1 rst", sys_rst_o, 0);
    // R2 unmapped and write-only reads
    rd(12'h010, v); check("R2 unmapped", v, 0);
    rd(A_ICLR, v);  check("R2 iclr reads 0", v, 0);

    // R6 R7 R8 R9 sweep over small reload values
    for (int l = 0; l <= 4; l++) begin
      do_reset();
      wr(A_LOAD, l);
      rd(A_CNT, v); check("R5 load restarts", v, l);
      tick(2);
      rd(A_CNT, v); check("R11 stopped holds", v, l);
      wr(A_CTRL, 1);
      for (int k = 1; k <= l; k++) begin
        tick(1);
        rd(A_CNT, v); check("R6 decrement", v, l - k);
        check("R7 no early irq", irq_o, 0);
      end
      tick(1);
      check("R7 irq on expiry", irq_o, 1);
      rd(A_CNT, v); check("R6 reload on expiry", v, l);
      wr(A_ICLR, 32'hDEAD);
      check("R8 clear irq", irq_o, 0);
      rd(A_CNT, v); check("R8 reload", v, l);
      wr(A_CTRL, 3);
      tick(l + 1);
      check("R7 irq first period", irq_o, 1);
      check("R9 no reset after one", sys_rst_o, 0);
      tick(l);
      check("R9 not early", sys_rst_o, 0);
      tick(1);
      check("R9 reset second expiry", sys_rst_o, 1);
      wr(A_CTRL, 0);
      tick(1);
      check("R9 sticky", sys_rst_o, 1);
      check("R11 irq masked", irq_o, 0);
    end
    do_reset();
    check("R9 cleared by rst_n", sys_rst_o, 0);

    // R10 no reset when bit1 clear
    wr(A_LOAD, 1); wr(A_CTRL, 1);
    tick(6);
    check("R10 irq pending", irq_o, 1);
    check("R10 no reset", sys_rst_o, 0);
    // R11 stop
    wr(A_CTRL, 0);
    check("R11 irq low", irq_o, 0);
    rd(A_CNT, v);
    tick(3);
    begin
      logic [31:0] v2;
      rd(A_CNT, v2); check("R11 count holds", v2, v);
    end

    // Clearing between periods prevents reset (R8 R9)
    do_reset();
    wr(A_LOAD, 2); wr(A_CTRL, 3);
    tick(3);
    check("R7 irq", irq_o, 1);
    wr(A_ICLR, 0);
    tick(3);
    check("R8 irq again", irq_o, 1);
    check("R9 cleared no reset", sys_rst_o, 0);

    // R3 R4 key
    do_reset();
    wr(A_LOAD, 7);
    wr(A_KEY, 0);
    rd(A_KEY, v); check("R3 closed reads 1", v, 1);
    wr(A_LOAD, 9);
    rd(A_LOAD, v); check("R4 load ignored", v, 7);
    rd(A_CNT, v);  check("R4 count untouched", v, 7);
    wr(A_CTRL, 3);
    rd(A_CTRL, v); check("R4 ctrl ignored", v, 0);
    wr(A_KEY, 32'h1ACCE550);
    rd(A_KEY, v); check("R3 wrong key stays closed", v, 1);
    wr(A_KEY, KEY);
    rd(A_KEY, v); check("R3 key opens", v, 0);
    wr(A_LOAD, 9);
    rd(A_LOAD, v); check("R3 write after open", v, 9);
    // R4 clear ignored while closed
    wr(A_LOAD, 0); wr(A_CTRL, 1);
    tick(1);
    check("R7 irq load 0", irq_o, 1);
    wr(A_KEY, 32'h0);
    wr(A_ICLR, 0);
    check("R4 clear ignored", irq_o, 1);

    // R5 refresh keeps interrupt away
    do_reset();
    wr(A_LOAD, 3); wr(A_CTRL, 1);
    tick(3);
    wr(A_KEY, 0); wr(A_KEY, KEY);
    wr(A_LOAD, 3);
    wr(A_KEY, 0);
    rd(A_CNT, v); check("R5 refreshed count", v, 3);
    tick(3);
    check("R5 no irq after refresh", irq_o, 0);

    // R12 restart wins over simultaneous tick at count 0
    wr(A_KEY, KEY);
    @(negedge clk);
    bus_addr = A_ICLR; bus_we = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_en = 1'b0;
    rd(A_CNT, v); check("R12 count reloaded", v, 3);
    check("R12 no expiry", irq_o, 0);
    tick(1);
    @(negedge clk);
    bus_addr = A_LOAD; bus_wdata = 5; bus_we = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_en = 1'b0;
    rd(A_CNT, v); check("R12 load beats tick", v, 5);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule